// File: doc/BRIEF.md
# Multi-Master I2C Byte Transmitter with Arbitration

This block is the transmit half of an I2C master that shares its bus with other masters. It generates Start, Repeated Start, Stop and Acknowledge sequences and shifts a byte out most significant bit first. It drives the open-drain lines through active-high pull-low enables and reads back the real line levels. Every time it releases SDA for a '1' it compares that bit with the sampled SDA level at the end of the SCL-high phase. It makes the same comparison wherever the sequence expects SDA to be high. When the comparison fails, the block has lost the bus. It aborts the byte or sequence, releases both lines, drops the buffer-full flag and any in-progress control bit, raises a sticky collision flag and returns to idle.

In idle the block keeps watching the bus. A Stop condition made by another master raises the interrupt flag, which tells software that the bus is free again. A byte written after a lost arbitration waits in the buffer. It is sent from its first bit once software has requested, and the block has completed, a new Start. Each bus phase lasts `CLK_DIV` clock cycles. The SCL-high phases stretch while another device holds SCL low.

The controller has these states:
- Resting states: `ST_IDLE` (bus released) and `ST_HOLD` (SCL held low, bus owned).
- Start states: `ST_SCHK` (both lines released and checked), `ST_SSDA` (SDA low, SCL high) and `ST_SSCL` (both low).
- Repeated Start states: `ST_RLOW` (SCL low, SDA released) and `ST_RHIGH` (SCL released, SDA checked), which then continue through `ST_SSDA` and `ST_SSCL`.
- Bit states: `ST_BLOW` (data placed while SCL is low) and `ST_BHIGH` (SCL released, bit compared).
- Acknowledge states: `ST_ALOW` and `ST_AHIGH`.
- Stop states: `ST_PLOW` (both low), `ST_PSCL` (SCL released) and `ST_PSDA` (SDA released and checked).

The transitions are:
- IDLE to SCHK on a start request.
- HOLD to BLOW when the buffer is full. Otherwise HOLD goes to RLOW, ALOW or PLOW on a request, in that order of priority.
- Along each chain, one state to the next on every phase tick.
- SSCL and AHIGH to HOLD, and PSDA to IDLE.
- BHIGH to BLOW, or to HOLD after the last bit.
- Any checking state to IDLE on a collision.

Top module: `i2c_arb_master`

## Requirements
- R1: Bits go out MSB first. Each bit has a SCL-low phase of `CLK_DIV` cycles, with SDA pulled low for a '0' and released for a '1', followed by a SCL-released phase of `CLK_DIV` cycles. During the released phase the SDA drive does not change. When the last bit ends, `buf_full` clears, `irq` sets, and the block holds SCL low with SDA released.
- R2: At the end of a SCL-high phase of a byte bit, if the bit is '1' and sampled SDA is 0, the block stops shifting. It releases both lines at once, sets `bus_coll`, clears `buf_full`, generates no further SCL pulses, and returns to idle.
- R3: A start request in idle releases both lines for one phase. If SDA or SCL reads 0 at the end of that phase, the block raises a collision. Otherwise it pulls SDA low for one phase, then pulls SCL low for one phase, then clears the start bit (`ctl_busy[0]`) and sets `irq`.
- R4: A repeated-start request while holding the bus releases SDA with SCL low, then releases SCL. If SDA reads 0 at the end of the high phase, the block raises a collision. Otherwise it completes as a Start, and `ctl_busy[1]` clears.
- R5: An acknowledge request while holding the bus drives `ack_val` for one clock pulse, with 0 meaning pulled low. If a released '1' is sampled as 0, the block raises a collision. Otherwise `ctl_busy[3]` clears and `irq` sets.
- R6: A stop request while holding the bus pulls SDA low, then releases SCL, then releases SDA. If SDA reads 0 at the end, the block raises a collision. Otherwise `ctl_busy[2]` clears, `irq` sets, and the block goes idle with both lines released.
- R7: A collision during any Start, Repeated Start, Acknowledge or Stop sequence clears every `ctl_busy` bit, releases both lines and sets `bus_coll`.
- R8: In idle, a Stop on the bus, meaning SDA rising while SCL stays high, sets `irq`.
- R9: A byte written in idle waits with `buf_full` set and produces no clock pulses. After the next Start it is sent from bit 7, including when an earlier byte was cut off by a collision.
- R10: A write while `buf_full` is set, or while a sequence or byte is in progress, is ignored and sets `wr_coll`. The byte being sent is not changed.
- R11: A start request is acted on only in idle. Repeated-start, acknowledge and stop requests are acted on only while holding the bus with an empty buffer. Requests in any other case leave the lines, `ctl_busy` and `irq` unchanged. At most one `ctl_busy` bit is set at a time.
- R12: After reset both lines are released and `buf_full`, `bus_coll`, `wr_coll`, `irq` and `ctl_busy` are 0. `clr_flags` clears `bus_coll`, `wr_coll` and `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_req | input | 1 | Pulse: request a Start |
| rstart_req | input | 1 | Pulse: request a Repeated Start |
| stop_req | input | 1 | Pulse: request a Stop |
| ack_req | input | 1 | Pulse: request an acknowledge bit |
| ack_val | input | 1 | Acknowledge level to send (0 = ACK, 1 = NACK) |
| wr_en | input | 1 | Pulse: write `wr_data` to the transmit buffer |
| wr_data | input | DATA_W | Byte to transmit |
| clr_flags | input | 1 | Pulse: clear `bus_coll`, `wr_coll`, `irq` |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 = pull SCL low |
| sda_oe | output | 1 | 1 = pull SDA low |
| buf_full | output | 1 | Transmit buffer holds a byte not yet fully sent |
| bus_coll | output | 1 | Sticky: arbitration lost / bus collision |
| wr_coll | output | 1 | Sticky: a write was rejected |
| irq | output | 1 | Sticky: sequence or byte done, or bus Stop seen in idle |
| ctl_busy | output | 4 | In-progress sequence: bit0 Start, bit1 Repeated Start, bit2 Stop, bit3 Acknowledge |

## Verification
The hardest case to reach from the ports is a lost arbitration in the middle of a byte. Another master must pull SDA low during the low phase just before one of this block's '1' bits, and the bus must then show the block going silent after exactly that bit. The bench models the open-drain bus as a wired AND of the block's enables and a second master's enables. It counts SCL rising edges and, once the first bit has been clocked and SCL has dropped, pulls SDA low. It then confirms that the clock count stops at two and that a later write goes out whole after a fresh Start.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HOLD,
        ST_SCHK,
        ST_SSDA,
        ST_SSCL,
        ST_RLOW,
        ST_RHIGH,
        ST_BLOW,
        ST_BHIGH,
        ST_ALOW,
        ST_AHIGH,
        ST_PLOW,
        ST_PSCL,
        ST_PSDA
    } arb_state_e;

    localparam int CTL_W      = 4;
    localparam int CTL_START  = 0;
    localparam int CTL_RSTART = 1;
    localparam int CTL_STOP   = 2;
    localparam int CTL_ACK    = 3;

endpackage

// File: rtl/i2c_arb_tick.sv
module i2c_arb_tick #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= tick ? '0 : cnt + CW'(1);
        end
    end
endmodule

// File: rtl/i2c_arb_shift.sv
module i2c_arb_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         shift,
    output logic         msb,
    output logic         last
);
    localparam int BW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  sreg;
    logic [BW-1:0] bcnt;

    assign msb  = sreg[W-1];
    assign last = (bcnt == BW'(W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            bcnt <= '0;
        end else if (load) begin
            sreg <= din;
            bcnt <= '0;
        end else if (shift) begin
            sreg <= {sreg[W-2:0], 1'b0};
            bcnt <= bcnt + BW'(1);
        end
    end
endmodule

// File: rtl/i2c_arb_master.sv
module i2c_arb_master
    import i2c_arb_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int CLK_DIV = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              rstart_req,
    input  logic              stop_req,
    input  logic              ack_req,
    input  logic              ack_val,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_flags,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              buf_full,
    output logic              bus_coll,
    output logic              wr_coll,
    output logic              irq,
    output logic [3:0]        ctl_busy
);
    arb_state_e st, st_nxt;

    logic tick, tick_en, tick_clr, stall;
    logic sh_msb, sh_last, sh_shift, wr_ok;
    logic coll, seq_done, byte_done, stop_seen;
    logic ack_bit, sda_q, scl_q;
    logic [CTL_W-1:0] ctl_set;

    assign wr_ok     = wr_en && !buf_full && (st == ST_IDLE || st == ST_HOLD);
    assign stall     = !scl_i && (st == ST_BHIGH || st == ST_AHIGH ||
                                  st == ST_RHIGH || st == ST_PSCL);
    assign tick_en   = (st != ST_IDLE) && (st != ST_HOLD) && !stall;
    assign tick_clr  = (st_nxt != st);
    assign sh_shift  = (st == ST_BHIGH) && tick && !coll;
    assign stop_seen = (st == ST_IDLE) && scl_q && scl_i && !sda_q && sda_i;

    i2c_arb_tick #(.DIV(CLK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .en    (tick_en),
        .tick  (tick)
    );

    i2c_arb_shift #(.W(DATA_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_ok),
        .din   (wr_data),
        .shift (sh_shift),
        .msb   (sh_msb),
        .last  (sh_last)
    );

    // Next state, sequence completion and collision detection
    always_comb begin
        st_nxt    = st;
        coll      = 1'b0;
        seq_done  = 1'b0;
        byte_done = 1'b0;
        ctl_set   = '0;
        unique case (st)
            ST_IDLE: begin
                if (start_req) begin
                    st_nxt             = ST_SCHK;
                    ctl_set[CTL_START] = 1'b1;
                end
            end
            ST_HOLD: begin
                if (buf_full) begin
                    st_nxt = ST_BLOW;
                end else if (rstart_req) begin
                    st_nxt              = ST_RLOW;
                    ctl_set[CTL_RSTART] = 1'b1;
                end else if (ack_req) begin
                    st_nxt           = ST_ALOW;
                    ctl_set[CTL_ACK] = 1'b1;
                end else if (stop_req) begin
                    st_nxt            = ST_PLOW;
                    ctl_set[CTL_STOP] = 1'b1;
                end
            end
            ST_SCHK: if (tick) begin
                if (!sda_i || !scl_i) coll = 1'b1;
                else                  st_nxt = ST_SSDA;
            end
            ST_SSDA: if (tick) st_nxt = ST_SSCL;
            ST_SSCL: if (tick) begin
                st_nxt   = ST_HOLD;
                seq_done = 1'b1;
            end
            ST_RLOW: if (tick) st_nxt = ST_RHIGH;
            ST_RHIGH: if (tick) begin
                if (!sda_i) coll = 1'b1;
                else        st_nxt = ST_SSDA;
            end
            ST_BLOW: if (tick) st_nxt = ST_BHIGH;
            ST_BHIGH: if (tick) begin
                if (sh_msb && !sda_i) begin
                    coll = 1'b1;
                end else if (sh_last) begin
                    st_nxt    = ST_HOLD;
                    byte_done = 1'b1;
                end else begin
                    st_nxt = ST_BLOW;
                end
            end
            ST_ALOW: if (tick) st_nxt = ST_AHIGH;
            ST_AHIGH: if (tick) begin
                if (ack_bit && !sda_i) begin
                    coll = 1'b1;
                end else begin
                    st_nxt   = ST_HOLD;
                    seq_done = 1'b1;
                end
            end
            ST_PLOW: if (tick) st_nxt = ST_PSCL;
            ST_PSCL: if (tick) st_nxt = ST_PSDA;
            ST_PSDA: if (tick) begin
                if (!sda_i) begin
                    coll = 1'b1;
                end else begin
                    st_nxt   = ST_IDLE;
                    seq_done = 1'b1;
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
        if (coll) st_nxt = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // Line drive per state (1 = pull low)
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (st)
            ST_IDLE, ST_SCHK, ST_RHIGH, ST_PSDA: begin
                scl_oe = 1'b0; sda_oe = 1'b0;
            end
            ST_HOLD, ST_RLOW: begin
                scl_oe = 1'b1; sda_oe = 1'b0;
            end
            ST_SSDA, ST_PSCL: begin
                scl_oe = 1'b0; sda_oe = 1'b1;
            end
            ST_SSCL, ST_PLOW: begin
                scl_oe = 1'b1; sda_oe = 1'b1;
            end
            ST_BLOW:  begin scl_oe = 1'b1; sda_oe = !sh_msb;  end
            ST_BHIGH: begin scl_oe = 1'b0; sda_oe = !sh_msb;  end
            ST_ALOW:  begin scl_oe = 1'b1; sda_oe = !ack_bit; end
            ST_AHIGH: begin scl_oe = 1'b0; sda_oe = !ack_bit; end
            default:  begin scl_oe = 1'b0; sda_oe = 1'b0;     end
        endcase
    end

    // Flags, control bits and line history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_full <= 1'b0;
            bus_coll <= 1'b0;
            wr_coll  <= 1'b0;
            irq      <= 1'b0;
            ctl_busy <= '0;
            ack_bit  <= 1'b0;
            sda_q    <= 1'b1;
            scl_q    <= 1'b1;
        end else begin
            sda_q <= sda_i;
            scl_q <= scl_i;
            if (coll || byte_done) buf_full <= 1'b0;
            else if (wr_ok)        buf_full <= 1'b1;
            if (coll)           bus_coll <= 1'b1;
            else if (clr_flags) bus_coll <= 1'b0;
            if (wr_en && !wr_ok) wr_coll <= 1'b1;
            else if (clr_flags)  wr_coll <= 1'b0;
            if (seq_done || byte_done || stop_seen) irq <= 1'b1;
            else if (clr_flags)                     irq <= 1'b0;
            if (coll || seq_done) ctl_busy <= '0;
            else                  ctl_busy <= ctl_busy | ctl_set;
            if (ctl_set[CTL_ACK]) ack_bit <= ack_val;
        end
    end
endmodule

// File: rtl/i2c_arb_chk.sv
module i2c_arb_chk
    import i2c_arb_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input arb_state_e st,
    input logic       tick,
    input logic       msb,
    input logic       sda_i,
    input logic       wr_en,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       buf_full,
    input logic       bus_coll,
    input logic       wr_coll,
    input logic       irq,
    input logic [3:0] ctl_busy
);
    AST_BIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BHIGH && $past(st) == ST_BHIGH) |-> $stable(sda_oe)); // R1

    AST_BYTE_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_full) |-> (irq || bus_coll)); // R1

    AST_ARB_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BHIGH && tick && msb && !sda_i) |=>
            (bus_coll && !scl_oe && !sda_oe && !buf_full)); // R2

    AST_COLL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_coll) |-> (ctl_busy == 4'b0 && !scl_oe && !sda_oe)); // R7

    AST_WR_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && buf_full) |=> wr_coll); // R10

    AST_CTL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctl_busy)); // R11
endmodule

bind i2c_arb_master i2c_arb_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .tick     (tick),
    .msb      (sh_msb),
    .sda_i    (sda_i),
    .wr_en    (wr_en),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .buf_full (buf_full),
    .bus_coll (bus_coll),
    .wr_coll  (wr_coll),
    .irq      (irq),
    .ctl_busy (ctl_busy)
);

// File: tb/i2c_arb_master_tb_top.sv
`timescale 1ns/1ps
module i2c_arb_master_tb_top;
    localparam int DIV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 0, rstart_req = 0, stop_req = 0, ack_req = 0, ack_val = 0;
    logic wr_en = 0, clr_flags = 0;
    logic [7:0] wr_data = '0;
    logic ext_scl = 0, ext_sda = 0;
    logic scl_oe, sda_oe, buf_full, bus_coll, wr_coll, irq;
    logic [3:0] ctl_busy;
    logic scl_bus, sda_bus;

    int errors = 0;
    int checks = 0;
    int rise_cnt = 0, hi_cnt = 0, start_cnt = 0, stop_cnt = 0;
    logic [7:0] cap = '0;
    logic scl_prev = 1'b1, sda_prev = 1'b1;

    always #10 clk = ~clk;

    assign scl_bus = !(scl_oe || ext_scl);
    assign sda_bus = !(sda_oe || ext_sda);

    i2c_arb_master #(.DATA_W(8), .CLK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .start_req(start_req), .rstart_req(rstart_req), .stop_req(stop_req),
        .ack_req(ack_req), .ack_val(ack_val),
        .wr_en(wr_en), .wr_data(wr_data), .clr_flags(clr_flags),
        .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .buf_full(buf_full),
        .bus_coll(bus_coll), .wr_coll(wr_coll), .irq(irq), .ctl_busy(ctl_busy)
    );

    // Bus monitor: clock edges, captured bits, Start/Stop conditions
    always @(posedge clk) begin
        if (scl_bus) hi_cnt <= hi_cnt + 1;
        if (scl_bus && !scl_prev) begin
            rise_cnt <= rise_cnt + 1;
            cap      <= {cap[6:0], sda_bus};
        end
        if (scl_bus && scl_prev && !sda_bus && sda_prev) start_cnt <= start_cnt + 1;
        if (scl_bus && scl_prev && sda_bus && !sda_prev) stop_cnt <= stop_cnt + 1;
        scl_prev <= scl_bus;
        sda_prev <= sda_bus;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // 0 start, 1 rstart, 2 stop, 3 ack, 4 clr
    task automatic pulse(input int which);
        case (which)
            0: start_req  = 1;
            1: rstart_req = 1;
            2: stop_req   = 1;
            3: ack_req    = 1;
            default: clr_flags = 1;
        endcase
        @(negedge clk);
        start_req = 0; rstart_req = 0; stop_req = 0; ack_req = 0; clr_flags = 0;
    endtask

    task automatic write(input logic [7:0] d);
        wr_data = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic wait_ctl_clear();
        for (int i = 0; i < 2000 && ctl_busy != 0; i++) @(negedge clk);
    endtask

    task automatic wait_not_full();
        for (int i = 0; i < 4000 && buf_full; i++) @(negedge clk);
    endtask

    task automatic wait_coll();
        for (int i = 0; i < 4000 && !bus_coll; i++) @(negedge clk);
    endtask

    task automatic go_hold();
        pulse(4);
        pulse(0);
        wait_ctl_clear();
    endtask

    task automatic t_reset();
        chk("R12", "scl_oe after reset", scl_oe, 0);
        chk("R12", "sda_oe after reset", sda_oe, 0);
        chk("R12", "flags after reset", {buf_full, bus_coll, wr_coll, irq}, 0);
        chk("R12", "ctl_busy after reset", ctl_busy, 0);
    endtask

    task automatic t_start();
        int s0;
        s0 = start_cnt;
        pulse(0);
        chk("R3", "start bit set", ctl_busy, 4'b0001);
        wait_ctl_clear();
        chk("R3", "start seen on bus", start_cnt - s0, 1);
        chk("R3", "irq after start", irq, 1);
        chk("R3", "holding SCL low", {scl_oe, sda_oe}, 2'b10);
        pulse(4);
        chk("R12", "clr_flags clears irq", irq, 0);
    endtask

    task automatic t_byte();
        int r0, h0;
        r0 = rise_cnt; h0 = hi_cnt;
        write(8'h3C);
        chk("R1", "buf_full after write", buf_full, 1);
        for (int i = 0; i < 2000 && (rise_cnt - r0) < 3; i++) @(negedge clk);
        write(8'hFF);
        chk("R10", "wr_coll on busy write", wr_coll, 1);
        wait_not_full();
        chk("R1", "byte on bus MSB first", cap, 8'h3C);
        chk("R10", "rejected write not sent", rise_cnt - r0, 8);
        chk("R1", "SCL high cycles per byte", hi_cnt - h0, 8 * DIV);
        chk("R1", "irq after byte", irq, 1);
        chk("R1", "holding after byte", {scl_oe, sda_oe, bus_coll}, 3'b100);
        pulse(4);
    endtask

    task automatic t_ack();
        int r0;
        r0 = rise_cnt;
        ack_val = 1;
        pulse(3);
        chk("R5", "ack bit set", ctl_busy, 4'b1000);
        wait_ctl_clear();
        chk("R5", "one ack clock", rise_cnt - r0, 1);
        chk("R5", "NACK level sent", cap[0], 1);
        chk("R5", "irq after ack", {irq, bus_coll}, 2'b10);
        pulse(4);
    endtask

    task automatic t_rstart();
        int s0;
        s0 = start_cnt;
        pulse(1);
        chk("R4", "rstart bit set", ctl_busy, 4'b0010);
        wait_ctl_clear();
        chk("R4", "repeated start on bus", start_cnt - s0, 1);
        chk("R4", "irq after rstart", {irq, bus_coll}, 2'b10);
        pulse(4);
    endtask

    task automatic t_stop();
        int p0;
        p0 = stop_cnt;
        pulse(2);
        chk("R6", "stop bit set", ctl_busy, 4'b0100);
        wait_ctl_clear();
        chk("R6", "stop on bus", stop_cnt - p0, 1);
        chk("R6", "lines released", {scl_oe, sda_oe}, 2'b00);
        chk("R6", "irq after stop", {irq, bus_coll}, 2'b10);
        pulse(4);
    endtask

    task automatic t_ignored();
        int r0;
        r0 = rise_cnt;
        pulse(2); pulse(1); pulse(3);
        cyc(3 * DIV);
        chk("R11", "idle requests ignored ctl", ctl_busy, 0);
        chk("R11", "idle requests ignored lines", {scl_oe, sda_oe, irq}, 3'b000);
        chk("R11", "no clocks from ignored", rise_cnt - r0, 0);
        go_hold();
        pulse(4);
        pulse(0);
        cyc(3 * DIV);
        chk("R11", "start in hold ignored", {ctl_busy, scl_oe, sda_oe, irq}, 7'b0000_100);
        pulse(2);
        wait_ctl_clear();
        pulse(4);
    endtask

    task automatic t_arb_data();
        int r0;
        go_hold();
        pulse(4);
        r0 = rise_cnt;
        write(8'hF0);
        for (int i = 0; i < 2000 && !((rise_cnt - r0) == 1 && !scl_bus); i++) @(negedge clk);
        ext_sda = 1;
        wait_coll();
        cyc(1);
        chk("R2", "bus_coll on lost bit", bus_coll, 1);
        chk("R2", "lines released", {scl_oe, sda_oe}, 2'b00);
        chk("R2", "buf_full cleared", buf_full, 0);
        chk("R2", "stopped after lost bit", rise_cnt - r0, 2);
        cyc(4 * DIV);
        chk("R2", "no further clocks", rise_cnt - r0, 2);
        pulse(4);
        ext_sda = 0;
        cyc(2);
        chk("R8", "bus stop sets irq in idle", irq, 1);
        pulse(4);
    endtask

    task automatic t_write_after_coll();
        int r0;
        r0 = rise_cnt;
        write(8'hC3);
        cyc(4 * DIV);
        chk("R9", "byte waits in idle", {buf_full, scl_oe, sda_oe}, 3'b100);
        chk("R9", "no clocks while waiting", rise_cnt - r0, 0);
        pulse(0);
        wait_not_full();
        chk("R9", "full byte from first bit", cap, 8'hC3);
        chk("R9", "eight clocks", rise_cnt - r0, 8);
        pulse(2);
        wait_ctl_clear();
        pulse(4);
    endtask

    task automatic t_start_coll();
        ext_sda = 1;
        cyc(2);
        pulse(4);
        pulse(0);
        wait_coll();
        cyc(1);
        chk("R3", "start collision flag", bus_coll, 1);
        chk("R7", "start bit cleared", ctl_busy, 0);
        chk("R7", "lines released", {scl_oe, sda_oe}, 2'b00);
        ext_sda = 0;
        cyc(2);
        pulse(4);
    endtask

    task automatic t_rstart_coll();
        go_hold();
        pulse(4);
        pulse(1);
        ext_sda = 1;
        wait_coll();
        cyc(1);
        chk("R4", "rstart collision flag", bus_coll, 1);
        chk("R7", "rstart bit cleared", {ctl_busy, scl_oe, sda_oe}, 6'b0);
        ext_sda = 0;
        cyc(2);
        pulse(4);
    endtask

    task automatic t_ack_coll();
        go_hold();
        pulse(4);
        ack_val = 1;
        pulse(3);
        ext_sda = 1;
        wait_coll();
        cyc(1);
        chk("R5", "ack collision flag", bus_coll, 1);
        chk("R7", "ack bit cleared", {ctl_busy, scl_oe, sda_oe}, 6'b0);
        ext_sda = 0;
        cyc(2);
        pulse(4);
    endtask

    task automatic t_stop_coll();
        go_hold();
        pulse(4);
        pulse(2);
        ext_sda = 1;
        wait_coll();
        cyc(1);
        chk("R6", "stop collision flag", bus_coll, 1);
        chk("R7", "stop bit cleared", {ctl_busy, scl_oe, sda_oe}, 6'b0);
        ext_sda = 0;
        cyc(2);
        pulse(4);
        chk("R12", "clr_flags clears bus_coll", {bus_coll, wr_coll, irq}, 3'b000);
    endtask

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(2);
        t_reset();
        t_start();
        t_byte();
        t_ack();
        t_rstart();
        t_stop();
        t_ignored();
        t_arb_data();
        t_write_after_coll();
        t_start_coll();
        t_rstart_coll();
        t_ack_coll();
        t_stop_coll();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R1..R12 run: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule